// File: doc/BRIEF.md
# Codec Frame-Sync Serial Data Port

This block is the slave side of a codec's serial data link. The host supplies a bit clock (`sclk`) and a frame pulse (`fs`). The block samples both on its own system clock and finds their edges there. A frame starts when `fs` goes from high to low, as seen at two successive rising edges of `sclk`. The frame then lasts sixteen `sclk` periods. During the frame, `dout` shifts one bit per period, most significant bit first. Each bit changes on a rising edge of `sclk`, so it is stable when the host captures it on the following falling edge.

The `frameSec` input is sampled when a frame starts and sets the frame's kind. A primary frame carries one two's-complement converter sample. That sample is either the full 16-bit word or a 15-bit sample with a master/slave flag in the least significant bit. A secondary frame carries register readback. During every secondary frame the port also shifts in a 16-bit control word from `din`. That word either writes one byte of a small register bank or asks for one register to be returned in the next secondary frame.

Top module: `codec_frame_port`

## Requirements
- R1: After reset, `dout` and `frameDone` are 0, no read is pending, and every register in the bank holds 0.
- R2: A frame starts at a rising edge of `sclk` where `fs` is low and `fs` was high at the previous rising edge. From that edge on, `dout` presents the 16 bits of the frame word, most significant first. It changes only after rising edges of `sclk`, so bit 15 is valid at falling edge 0 and bit 0 is valid at falling edge 15.
- R3: In 16-bit mode (`fmt15` = 0), a primary frame sends `sampleIn` as it was when the frame started. A change to `sampleIn` during the frame does not alter the bits that are sent.
- R4: In 15+1 mode (`fmt15` = 1), a primary frame sends `sampleIn[15:1]` in bits 15..1 and `isMaster` in bit 0.
- R5: `dout` is 0 outside the sixteen bit periods of a frame.
- R6: `frameDone` pulses for exactly one system clock after the rising edge of `sclk` that ends bit period 15. It does not pulse at any other time.
- R7: In a secondary frame, `din` is captured on falling edges of `sclk`, most significant bit first. Bit 12 of the captured word is the read flag and bits 11..9 are the register address. Both are taken at the end of the frame.
- R8: A secondary control word with bit 12 = 0 writes its bits 7..0 into the register at the address in bits 11..9.
- R9: After a secondary word with bit 12 = 1, the next secondary frame sends {5'b00000, address[2:0], register[7:0]}.
- R10: A secondary frame sends all zeros when the previous secondary control word had no read request, or when no secondary word has arrived since reset.
- R11: A frame start that occurs in the middle of a frame restarts the bit count and loads a fresh word. The interrupted frame produces no `frameDone`.
- R12: `din` is ignored during primary frames: a read request sent in a primary frame does not change what the next secondary frame returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bit clock from the host |
| fs | input | 1 | Frame pulse; a high-to-low transition starts a frame |
| frameSec | input | 1 | Frame kind sampled at frame start: 1 secondary, 0 primary |
| din | input | 1 | Serial control word from the host |
| sampleIn | input | 16 | Two's-complement converter sample |
| fmt15 | input | 1 | 1 selects the 15-bit sample plus flag format |
| isMaster | input | 1 | Flag value sent in bit 0 in 15+1 mode |
| dout | output | 1 | Serial output data |
| frameDone | output | 1 | One-clock pulse at the end of each completed frame |

## Verification
A wrong bit counter shows up on `dout` at the next falling edge of `sclk`. The word is either shifted by one position or it runs past its sixteenth bit, and then the trailing idle check sees a non-zero bit or `frameDone` appears at the wrong time. Wrong pending-read or address state stays hidden until the next secondary frame, so the bench runs secondary frames back to back and compares each readback word with the bank contents it has tracked from its own writes. A faulty restart leaves a partial word behind, and the first full frame after the interruption exposes it.

// File: rtl/codec_frame_pkg.sv
package codec_frame_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic load;     // frame start: latch a fresh word
    logic shift;    // advance to next output bit
    logic finish;   // bit period 15 ended
    logic takeDin;  // sample din into control shifter
    logic dinBit;   // synchronized din value
    logic isSec;    // kind of current frame
  } portStrobe_t;
endpackage

// File: rtl/codec_frame_ctrl.sv
module codec_frame_ctrl
  import codec_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             fs,
  input  logic             din,
  input  logic             frameSec,
  output portStrobe_t      strb,
  output logic             active,
  output logic [CNT_W-1:0] bitCnt
);
  localparam int IN_N = 4;

  logic [IN_N-1:0] syncChain [SYNC_STAGES];
  logic sclkS, fsS, dinS, secS;
  logic sclkPrev, fsAtRise, secQ;
  logic rise, fall, start, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= '0;
    else       syncChain[0] <= {sclk, fs, din, frameSec};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[s] <= '0;
      else       syncChain[s] <= syncChain[s-1];
    end
  end

  assign {sclkS, fsS, dinS, secS} = syncChain[SYNC_STAGES-1];

  assign rise    = sclkS & ~sclkPrev;
  assign fall    = ~sclkS & sclkPrev;
  assign start   = rise & ~fsS & fsAtRise;
  assign lastBit = (bitCnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      fsAtRise <= 1'b0;
      active   <= 1'b0;
      bitCnt   <= '0;
      secQ     <= 1'b0;
      strb     <= '0;
    end else begin
      sclkPrev <= sclkS;
      if (rise) fsAtRise <= fsS;

      if (start) begin
        active <= 1'b1;
        bitCnt <= '0;
        secQ   <= secS;
      end else if (rise && active) begin
        if (lastBit) active <= 1'b0;
        else         bitCnt <= bitCnt + 1'b1;
      end

      strb.load    <= start;
      strb.shift   <= rise & active & ~start & ~lastBit;
      strb.finish  <= rise & active & ~start & lastBit;
      strb.takeDin <= fall & active;
      strb.dinBit  <= dinS;
      strb.isSec   <= start ? secS : secQ;
    end
  end
endmodule

// File: rtl/codec_frame_dp.sv
module codec_frame_dp
  import codec_frame_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  portStrobe_t        strb,
  input  logic [FRAME_W-1:0] sampleIn,
  input  logic               fmt15,
  input  logic               isMaster,
  output logic               dout,
  output logic               frameDone
);
  localparam int REG_N    = 1 << ADDR_W;
  localparam int PAD_W    = FRAME_W - ADDR_W - DATA_W;
  localparam int READ_POS = 12;
  localparam int ADDR_LSB = 9;

  logic [DATA_W-1:0]  regBank [REG_N];
  logic               pendRead;
  logic [ADDR_W-1:0]  pendAddr;
  logic [FRAME_W-1:0] outShift, sampleWord, readWord, loadWord;
  logic [READ_POS:0]  dinShift;
  logic               ctlRead;
  logic [ADDR_W-1:0]  ctlAddr;
  logic [DATA_W-1:0]  ctlData;

  assign ctlRead = dinShift[READ_POS];
  assign ctlAddr = dinShift[ADDR_LSB +: ADDR_W];
  assign ctlData = dinShift[DATA_W-1:0];

  assign sampleWord = fmt15 ? {sampleIn[FRAME_W-1:1], isMaster} : sampleIn;
  assign readWord   = {{PAD_W{1'b0}}, pendAddr, regBank[pendAddr]};
  assign loadWord   = strb.isSec ? (pendRead ? readWord : '0) : sampleWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dout      <= 1'b0;
      outShift  <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strb.finish;
      if (strb.load) begin
        dout     <= loadWord[FRAME_W-1];
        outShift <= {loadWord[FRAME_W-2:0], 1'b0};
      end else if (strb.shift) begin
        dout     <= outShift[FRAME_W-1];
        outShift <= {outShift[FRAME_W-2:0], 1'b0};
      end else if (strb.finish) begin
        dout <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dinShift <= '0;
    else if (strb.takeDin) dinShift <= {dinShift[READ_POS-1:0], strb.dinBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendRead <= 1'b0;
      pendAddr <= '0;
    end else if (strb.finish && strb.isSec) begin
      pendRead <= ctlRead;
      pendAddr <= ctlAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_N; i++) regBank[i] <= '0;
    end else if (strb.finish && strb.isSec && !ctlRead) begin
      regBank[ctlAddr] <= ctlData;
    end
  end
endmodule

// File: rtl/codec_frame_port.sv
module codec_frame_port
  import codec_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        fs,
  input  logic        frameSec,
  input  logic        din,
  input  logic [15:0] sampleIn,
  input  logic        fmt15,
  input  logic        isMaster,
  output logic        dout,
  output logic        frameDone
);
  portStrobe_t      strb;
  logic             active;
  logic [CNT_W-1:0] bitCnt;

  codec_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .fs(fs), .din(din),
    .frameSec(frameSec), .strb(strb), .active(active), .bitCnt(bitCnt)
  );

  codec_frame_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleIn(sampleIn),
    .fmt15(fmt15), .isMaster(isMaster), .dout(dout), .frameDone(frameDone)
  );
endmodule

// File: rtl/codec_frame_chk.sv
module codec_frame_chk
  import codec_frame_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input portStrobe_t      strb,
  input logic             active,
  input logic [CNT_W-1:0] bitCnt,
  input logic             dout,
  input logic             frameDone
);
  // R5: output low while no frame is in progress
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !$past(active)) |-> !dout);

  // R6: completion strobe lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R6: completion strobe only after the last bit period
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(active, 2) && $past(bitCnt, 2) == CNT_W'(FRAME_W - 1)));

  // R2: output changes only on a frame step
  a_r2_dout_steady: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.shift || strb.finish) |=> $stable(dout));

  // R11: every load begins at bit zero of an active frame
  a_r11_load_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (active && bitCnt == '0));
endmodule

bind codec_frame_port codec_frame_chk u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .active(active),
  .bitCnt(bitCnt), .dout(dout), .frameDone(frameDone)
);

// File: tb/codec_frame_port_tb.sv
module codec_frame_port_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, fs = 1'b0, frameSec = 1'b0, din = 1'b0;
  logic [15:0] sampleIn = '0;
  logic fmt15 = 1'b0, isMaster = 1'b0;
  logic dout, frameDone;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  codec_frame_port u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .fs(fs), .frameSec(frameSec),
    .din(din), .sampleIn(sampleIn), .fmt15(fmt15), .isMaster(isMaster),
    .dout(dout), .frameDone(frameDone)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic dinBit, output logic doutBit, inout int doneCnt);
    sclk = 1'b1;
    din  = dinBit;
    repeat (HALF) begin @(negedge clk); doneCnt += int'(frameDone); end
    doutBit = dout;
    sclk = 1'b0;
    repeat (HALF) begin @(negedge clk); doneCnt += int'(frameDone); end
  endtask

  task automatic runFrame(input bit sec, input logic [15:0] ctl, input bit midChg,
                          input logic [15:0] midVal, input string tag,
                          output logic [15:0] got);
    int dn;
    logic b;
    fs = 1'b1; frameSec = sec; dn = 0;
    tick(1'b0, b, dn);
    chk({tag, " R5 lead idle"}, {15'b0, b}, 16'h0);
    fs = 1'b0; dn = 0;
    for (int i = 0; i < 16; i++) begin
      tick(ctl[15-i], b, dn);
      got[15-i] = b;
      if (midChg && i == 4) sampleIn = midVal;
    end
    chk({tag, " R6 no strobe mid-frame"}, 16'(dn), 16'd0);
    dn = 0;
    tick(1'b0, b, dn);
    chk({tag, " R5 trail idle"}, {15'b0, b}, 16'h0);
    chk({tag, " R6 one strobe"}, 16'(dn), 16'd1);
  endtask

  task automatic testReset();
    chk("R1 dout after reset", {15'b0, dout}, 16'h0);
    chk("R1 frameDone after reset", {15'b0, frameDone}, 16'h0);
  endtask

  task automatic testPrimary16();
    logic [15:0] got;
    fmt15 = 1'b0;
    sampleIn = 16'hB5C3;
    runFrame(1'b0, 16'h0, 1'b0, 16'h0, "R2 p16", got);
    chk("R2 sample B5C3 msb first", got, 16'hB5C3);
    sampleIn = 16'h8000;
    runFrame(1'b0, 16'h0, 1'b0, 16'h0, "R2 neg", got);
    chk("R2 most negative sample", got, 16'h8000);
  endtask

  task automatic testLatch();
    logic [15:0] got;
    fmt15 = 1'b0;
    sampleIn = 16'h1234;
    runFrame(1'b0, 16'h0, 1'b1, 16'hFFFF, "R3 latch", got);
    chk("R3 sample held through frame", got, 16'h1234);
  endtask

  task automatic testFmt15();
    logic [15:0] got;
    fmt15 = 1'b1;
    isMaster = 1'b1; sampleIn = 16'hA5A4;
    runFrame(1'b0, 16'h0, 1'b0, 16'h0, "R4 master", got);
    chk("R4 15+1 master flag", got, 16'hA5A5);
    isMaster = 1'b0; sampleIn = 16'h5A5B;
    runFrame(1'b0, 16'h0, 1'b0, 16'h0, "R4 slave", got);
    chk("R4 15+1 slave flag", got, 16'h5A5A);
    fmt15 = 1'b0;
  endtask

  task automatic testRegisters();
    logic [15:0] got;
    sampleIn = 16'h0F0F;
    // read request for unwritten reg 7 (bit12=1, addr bits 11..9)
    runFrame(1'b1, 16'h1E00, 1'b0, 16'h0, "R10 first", got);
    chk("R10 zeros before any request", got, 16'h0000);
    // write reg 5 <= A7 (bit12=0); returns reg 7 from reset
    runFrame(1'b1, 16'h0AA7, 1'b0, 16'h0, "R1 bank", got);
    chk("R1 unwritten reg reads zero", got, 16'h0700);
    // read reg 5
    runFrame(1'b1, 16'h1A00, 1'b0, 16'h0, "R10 after write", got);
    chk("R10 zeros after write word", got, 16'h0000);
    // primary frame in between with a read request on din
    runFrame(1'b0, 16'h1400, 1'b0, 16'h0, "R12 primary", got);
    chk("R12 primary still sends sample", got, 16'h0F0F);
    // write reg 2 <= 3C, returns reg 5
    runFrame(1'b1, 16'h043C, 1'b0, 16'h0, "R9 read5", got);
    chk("R9 R8 R7 readback reg5", got, 16'h05A7);
    // read reg 2
    runFrame(1'b1, 16'h1400, 1'b0, 16'h0, "R10 no req", got);
    chk("R10 zeros after write word again", got, 16'h0000);
    // primary frame with a read request for reg 5 must be ignored
    runFrame(1'b0, 16'h1A00, 1'b0, 16'h0, "R12 ignored", got);
    runFrame(1'b1, 16'h0000, 1'b0, 16'h0, "R9 read2", got);
    chk("R12 R9 readback reg2", got, 16'h023C);
  endtask

  task automatic testRestart();
    logic [15:0] got;
    logic [5:0] head;
    logic b;
    int dn;
    fmt15 = 1'b0;
    sampleIn = 16'hC3A5;
    fs = 1'b1; frameSec = 1'b0; dn = 0;
    tick(1'b0, b, dn);
    fs = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(1'b0, b, dn); head[5-i] = b; end
    fs = 1'b1;
    tick(1'b0, b, dn); head[0] = b;
    chk("R2 R11 partial frame bits", {10'b0, head}, {10'b0, 6'b110000});
    sampleIn = 16'h6E19;
    fs = 1'b0;
    for (int i = 0; i < 16; i++) begin tick(1'b0, b, dn); got[15-i] = b; end
    chk("R11 restarted frame word", got, 16'h6E19);
    chk("R11 no strobe for cut frame", 16'(dn), 16'd0);
    dn = 0;
    tick(1'b0, b, dn);
    chk("R11 strobe after restarted frame", 16'(dn), 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testPrimary16();
    testLatch();
    testFmt15();
    testRegisters();
    testRestart();
    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule